// File: doc/BRIEF.md
# Receive Byte Buffer with Threshold Flow Control

This block sits between a serial receiver and a register-read path. Each byte the receiver delivers is stored in a 16-entry first-in first-out buffer. The reader always sees the oldest stored byte on its data output, and pulses a read strobe to consume it. Status outputs report whether the buffer is empty or full, and whether a byte has been lost because the buffer was full.

Two independent 2-bit codes set two thresholds. One sets when the data-ready flag is raised. The other sets when the request-to-send output is withdrawn, so a remote sender stops before the buffer overflows. A polarity input selects whether request-to-send is asserted high or low. All flags come straight from the registered fill count, so they change in the cycle after the strobe that changes the count. The reset is active-low and asynchronous.

Top module: `rxf_trig_fifo`

## Requirements
- R1: While reset is held and after it is released, before any byte is written, the outputs are empty_o=1, full_o=0, ovf_o=0 and data_rdy_o=0, and rts_o is at its active level.
- R2: rd_data_o always shows the oldest stored byte. Bytes leave in the order they were written. rd_data_o does not change while no read is made.
- R3: The ready code maps to a threshold in bytes: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14. data_rdy_o is 1 exactly when the stored count is greater than or equal to that threshold.
- R4: The request-to-send code uses the same mapping (0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14). Request-to-send is active while the count is below the threshold and inactive once the count reaches it.
- R5: With rts_low_act_i=1, active means rts_o=0. With rts_low_act_i=0, active means rts_o=1.
- R6: empty_o is 1 exactly when the count is 0. full_o is 1 exactly when the count is 16. The two flags are never 1 together.
- R7: A write while the buffer is full and no read is made is dropped, and it sets ovf_o. ovf_o stays set until ovf_clr_i is pulsed. If a drop and a clear happen in the same cycle, the flag stays set.
- R8: A read and a write in the same cycle on a non-empty buffer leave the count unchanged. This includes a full buffer, where the write is accepted.
- R9: A read strobe on an empty buffer has no effect. A write in the same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Received byte strobe |
| wr_data_i | input | 8 | Received byte |
| rd_en_i | input | 1 | Consume the oldest byte |
| ready_lvl_i | input | 2 | Data-ready threshold code |
| rts_lvl_i | input | 2 | Request-to-send threshold code |
| rts_low_act_i | input | 1 | 1: rts_o is active low, 0: rts_o is active high |
| ovf_clr_i | input | 1 | Clears the overflow flag (write one to clear) |
| rd_data_o | output | 8 | Oldest stored byte |
| data_rdy_o | output | 1 | Count has reached the ready threshold |
| empty_o | output | 1 | Buffer is empty |
| full_o | output | 1 | Buffer holds 16 bytes |
| ovf_o | output | 1 | Sticky overflow flag |
| rts_o | output | 1 | Request-to-send pin |

## Verification
The hardest conditions to reach are those at the full boundary. These are a dropped write racing an overflow clear, and a combined read and write on a full buffer, which must accept the new byte. The stimulus reaches them by filling the buffer to exactly sixteen bytes with no reads, then applying those cycles directly. It then drains the buffer so the scoreboard can confirm that the order of the survivors is intact. Each threshold code is swept across a full fill and drain, once under each request-to-send polarity. This places every crossing point of both flags under observation.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned LVL_W = 2;

  // threshold in bytes for a 2-bit level code
  function automatic logic [31:0] lvl_bytes(input logic [LVL_W-1:0] code);
    case (code)
      2'd0:    return 32'd1;
      2'd1:    return 32'd4;
      2'd2:    return 32'd8;
      default: return 32'd14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rxf_level_cmp.sv
module rxf_level_cmp
  import rxf_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0]    count_i,
  input  logic [LVL_W-1:0] code_i,
  output logic             reached_o
);
  assign reached_o = 32'(count_i) >= lvl_bytes(code_i);
endmodule

// File: rtl/rxf_trig_fifo.sv
module rxf_trig_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [1:0]    ready_lvl_i,
  input  logic [1:0]    rts_lvl_i,
  input  logic          rts_low_act_i,
  input  logic          ovf_clr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          data_rdy_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          rts_o
);
  logic [CW-1:0] count;
  logic push, pop, drop, rts_reached, ovf_q;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign pop     = rd_en_i & ~empty_o;
  // a full buffer still accepts a byte when a read frees a slot
  assign push    = wr_valid_i & (~full_o | pop);
  assign drop    = wr_valid_i & ~push;

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (wr_data_i),
    .rdata_o (rd_data_o),
    .count_o (count)
  );

  rxf_level_cmp #(.CW(CW)) u_rdy_cmp (
    .count_i   (count),
    .code_i    (ready_lvl_i),
    .reached_o (data_rdy_o)
  );

  rxf_level_cmp #(.CW(CW)) u_rts_cmp (
    .count_i   (count),
    .code_i    (rts_lvl_i),
    .reached_o (rts_reached)
  );

  // active while below threshold; polarity applied last
  assign rts_o = rts_low_act_i ? rts_reached : ~rts_reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end
  assign ovf_o = ovf_q;
endmodule

// File: rtl/rxf_trig_fifo_chk.sv
module rxf_trig_fifo_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic [DW-1:0] wr_data_i,
  input logic          rd_en_i,
  input logic [1:0]    ready_lvl_i,
  input logic [1:0]    rts_lvl_i,
  input logic          rts_low_act_i,
  input logic          ovf_clr_i,
  input logic [DW-1:0] rd_data_o,
  input logic          data_rdy_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic          rts_o
);
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R6
  AST_RDY_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_lvl_i == 2'd0) |-> (data_rdy_o == !empty_o)); // R3
  AST_RTS_EMPTY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rts_o == !rts_low_act_i)); // R5
  AST_DROP_SETS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_valid_i && !rd_en_i) |=> (full_o && ovf_o)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R7
  AST_SIMUL_KEEPS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && rd_en_i && !empty_o) |=> ($stable(empty_o) && $stable(full_o))); // R8
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_valid_i) |=> empty_o); // R9
  AST_HEAD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && !empty_o) |=> $stable(rd_data_o)); // R2
endmodule

bind rxf_trig_fifo rxf_trig_fifo_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_rxf_trig_fifo.sv
module tb_rxf_trig_fifo;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0, rts_low = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] rdy_lvl = '0, rts_lvl = '0;
  logic [7:0] rd_data;
  logic data_rdy, empty, full, ovf, rts;

  int total = 0, bad = 0;
  int cnt_m = 0;
  bit ovf_m = 0;
  logic [7:0] q_m[$];
  bit done = 0;

  always #5 clk = ~clk;

  rxf_trig_fifo dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .ready_lvl_i(rdy_lvl), .rts_lvl_i(rts_lvl),
    .rts_low_act_i(rts_low), .ovf_clr_i(ovf_clr), .rd_data_o(rd_data),
    .data_rdy_o(data_rdy), .empty_o(empty), .full_o(full), .ovf_o(ovf), .rts_o(rts)
  );

  function automatic int thr(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares outputs, then applies the pending edge to the model
  always @(negedge clk) begin
    if (!rst_ni) begin
      cnt_m = 0; ovf_m = 0; q_m.delete();
    end else if (!done) begin
      bit act_rts, do_rd, do_wr;
      chk("R6 empty", empty, cnt_m == 0);
      chk("R6 full", full, cnt_m == 16);
      chk("R3 data_rdy", data_rdy, cnt_m >= thr(rdy_lvl));
      act_rts = cnt_m < thr(rts_lvl);
      chk("R4/R5 rts", rts, rts_low ? !act_rts : act_rts);
      chk("R7 ovf", ovf, ovf_m);
      do_rd = rd_en && cnt_m > 0;
      if (do_rd) chk("R2 read data", rd_data, q_m[0]);
      do_wr = wr_valid && (cnt_m < 16 || do_rd);
      if (wr_valid && !do_wr) ovf_m = 1;
      else if (ovf_clr) ovf_m = 0;
      if (do_rd) begin void'(q_m.pop_front()); cnt_m--; end
      if (do_wr) begin q_m.push_back(wr_data); cnt_m++; end
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit r, input bit c);
    @(posedge clk); #2;
    wr_valid = w; wr_data = d; rd_en = r; ovf_clr = c;
  endtask
  task automatic idle(); step(0, 0, 0, 0); endtask
  task automatic fill(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) step(1, base + 8'(i), 0, 0);
    idle();
  endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0);
    idle();
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rdy_lvl = 2'd1; rts_lvl = 2'd1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 empty in reset", empty, 1);
    chk("R1 ovf in reset", ovf, 0);
    rst_ni = 1'b1;
    idle();
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 data_rdy", data_rdy, 0);
    chk("R1 rts active high", rts, 1);

    // R9: reads on empty do nothing; a write in the same cycle is kept
    step(0, 0, 1, 0); step(0, 0, 1, 0); idle();
    chk("R9 still empty", empty, 1);
    step(1, 8'hA5, 1, 0); idle();
    chk("R9 write kept", empty, 0);
    chk("R9 head", rd_data, 8'hA5);
    drain(1);

    // R3/R4/R5: sweep every code through a full fill and drain, both polarities
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        rts_low = p[0]; rdy_lvl = 2'(c); rts_lvl = 2'(3 - c);
        for (int i = 0; i < 16; i++) step(1, 8'(16 * c + i + p), 0, 0);
        idle();
        chk("R6 full after 16", full, 1);
        chk("R2 head is first byte", rd_data, 8'(16 * c + p));
        drain(16);
      end
    end

    // R8: simultaneous read+write mid-level keeps count (ready code 2 -> 8 bytes)
    rdy_lvl = 2'd2; rts_lvl = 2'd2; rts_low = 1'b1;
    fill(8, 8'h40);
    for (int i = 0; i < 3; i++) step(1, 8'h60 + 8'(i), 1, 0);
    idle();
    chk("R8 count stays at 8 rdy", data_rdy, 1);
    chk("R8 rts inactive low-act", rts, 1);
    drain(1);
    chk("R8 after single read rdy", data_rdy, 0);
    chk("R5 rts active low", rts, 0);
    drain(7);

    // R7: overflow drop, sticky, drop wins over clear, then clear
    rdy_lvl = 2'd3;
    fill(16, 8'h80);
    step(1, 8'hEE, 0, 0); idle();
    chk("R7 ovf set", ovf, 1);
    chk("R7 still full", full, 1);
    idle(); idle();
    chk("R7 sticky", ovf, 1);
    step(1, 8'hEF, 0, 1); idle();
    chk("R7 drop beats clear", ovf, 1);
    step(0, 0, 0, 1); idle();
    chk("R7 cleared", ovf, 0);
    // R8 on full: write accepted while reading
    step(1, 8'hC3, 1, 0); idle();
    chk("R8 full stays full", full, 1);
    chk("R8 no overflow", ovf, 0);
    drain(16);
    chk("R2 drained", empty, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule